// File: doc/BRIEF.md
# Protected Supervisor Register Bank

This block holds the configuration and fault-status state of a multi-rail power supervisor and rules on every incoming write, whether it targets one of its own registers or a location in the attached nonvolatile memory array. A volatile write-enable latch must be opened before any nonvolatile register or any memory location may change. A two-bit block-protect code fences off the upper quarter, the upper half or all of the array. A hardware lock, formed by an external protect pin together with a stored enable bit, freezes the nonvolatile registers. All nonvolatile writes also require the programming-voltage-present flag.

The bank exports the reset-delay code and one delay code per monitored channel to the sequencing logic. A volatile fault register records which channels have failed. Software arms it by writing ones, and a fail pulse from a channel clears that channel's bit. Writes to the fault register bypass the enable latch and the programming-voltage check. The permit output is combinational on the request; accepted register writes become visible on the read port after the next clock edge.

Top module: `wp_regbank`

## Requirements
- R1: After reset every register reads 00h at addresses 00h, 01h, 02h, 03h and FFh. The reset-delay code and all channel delay codes are 00.
- R2: At register address 00h only the data values 80h and 00h are permitted. 80h opens the enable latch (reads back 80h) and 00h closes it. Any other value is refused and leaves the latch unchanged. Latch writes need neither the programming voltage nor freedom from the hardware lock.
- R3: While the latch is closed, writes to registers 01h–03h and to any memory address are refused, and those registers keep their values.
- R4: The block-protect code (register 01h, bits 4:3) refuses memory writes as follows: 00 refuses none, 01 refuses C0h–FFh, 10 refuses 80h–FFh, and 11 refuses every address. Addresses below the fenced range stay writable.
- R5: While the protect pin is high and the lock-enable bit (register 01h, bit 7) is set, writes to registers 01h–03h are refused. Unfenced memory addresses remain writable.
- R6: Register 02h bits 3:2 drive the reset-delay code. Register 03h drives the channel codes, with channel k (k = 0..3) at bits 2k+1:2k.
- R7: A write to the fault register (FFh) loads data bits 3:0. A fail pulse on channel k clears bit k at the next edge. When a fail pulse and a write arrive in the same cycle, the fail pulse takes priority for that bit.
- R8: Fault-register writes are permitted with the latch closed and without the programming voltage.
- R9: Without the programming voltage, writes to registers 01h–03h and to memory are refused.
- R10: Unused bits read as 0 whatever was written: register 01h keeps only bits 7, 4 and 3; register 02h keeps only bits 3:2; the fault register keeps only bits 3:0.
- R11: Register-space writes to any address other than 00h–03h and FFh are refused and read back as 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; models first power-up, restoring factory defaults |
| wr_req | input | 1 | Write request valid |
| wr_is_mem | input | 1 | 1: request targets the memory array; 0: register space |
| wr_addr | input | ADDR_W | Register or memory address of the request |
| wr_data | input | 8 | Data byte of the request |
| wp_pin | input | 1 | External hardware write-protect pin |
| vpp_ok | input | 1 | Programming voltage present |
| fail_pulse | input | N_CH | Per-channel failure pulses |
| rd_addr | input | ADDR_W | Register read address |
| wr_permit | output | 1 | Current request is allowed |
| rd_data | output | 8 | Register read data |
| rst_dly_code | output | 2 | Reset-delay selection code |
| ch_dly_code | output | 2*N_CH | Per-channel delay codes, channel k at bits 2k+1:2k |

## Verification
A corrupted latch, lock-enable bit or protect code shows up at once as a wrong wr_permit in the same cycle as the next request that depends on it. The same fault is also visible on the very next read of register 00h or 01h. A wrongly updated delay field changes rst_dly_code or ch_dly_code one edge after the offending write. A fault bit that does not clear, or that clears on the wrong channel, is visible on the read port one cycle after the pulse. The directed scenarios therefore read back after every accepted or refused write.

// File: rtl/wpr_pkg.sv
package wpr_pkg;
   localparam int DATA_W = 8;
   localparam int REG_LATCH = 0;
   localparam int REG_PROT  = 1;
   localparam int REG_RDLY  = 2;
   localparam int REG_CDLY  = 3;
   localparam logic [DATA_W-1:0] LATCH_OPEN  = 8'h80;
   localparam logic [DATA_W-1:0] LATCH_CLOSE = 8'h00;

   typedef enum logic [2:0] {
      TGT_NONE, TGT_LATCH, TGT_PROT, TGT_RDLY, TGT_CDLY, TGT_FAULT, TGT_MEM
   } tgt_e;
endpackage

// File: rtl/wpr_blk_cmp.sv
module wpr_blk_cmp (
   input  logic [1:0] bp,
   input  logic [1:0] addr_hi,
   output logic       fenced
);
   always_comb begin
      unique case (bp)
         2'b00:   fenced = 1'b0;
         2'b01:   fenced = (addr_hi == 2'b11);
         2'b10:   fenced = addr_hi[1];
         default: fenced = 1'b1;
      endcase
   end
endmodule

// File: rtl/wpr_permit.sv
module wpr_permit
   import wpr_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter logic [ADDR_W-1:0] FAULT_ADDR = '1
) (
   input  logic              wr_req,
   input  logic              wr_is_mem,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wel,
   input  logic              wpen,
   input  logic [1:0]        bp,
   input  logic              wp_pin,
   input  logic              vpp_ok,
   output logic              permit,
   output tgt_e              tgt
);
   logic fenced;
   logic nv_reg_ok;
   logic ok;

   wpr_blk_cmp u_blk (
      .bp      (bp),
      .addr_hi (wr_addr[ADDR_W-1 -: 2]),
      .fenced  (fenced)
   );

   always_comb begin
      if (wr_is_mem)                             tgt = TGT_MEM;
      else if (wr_addr == ADDR_W'(REG_LATCH))    tgt = TGT_LATCH;
      else if (wr_addr == ADDR_W'(REG_PROT))     tgt = TGT_PROT;
      else if (wr_addr == ADDR_W'(REG_RDLY))     tgt = TGT_RDLY;
      else if (wr_addr == ADDR_W'(REG_CDLY))     tgt = TGT_CDLY;
      else if (wr_addr == FAULT_ADDR)            tgt = TGT_FAULT;
      else                                       tgt = TGT_NONE;
   end

   assign nv_reg_ok = wel & vpp_ok & ~(wp_pin & wpen);

   always_comb begin
      unique case (tgt)
         TGT_LATCH: ok = (wr_data == LATCH_OPEN) || (wr_data == LATCH_CLOSE);
         TGT_PROT,
         TGT_RDLY,
         TGT_CDLY:  ok = nv_reg_ok;
         TGT_FAULT: ok = 1'b1;
         TGT_MEM:   ok = wel & vpp_ok & ~fenced;
         default:   ok = 1'b0;
      endcase
   end

   assign permit = wr_req & ok;
endmodule

// File: rtl/wpr_fault.sv
module wpr_fault #(
   parameter int N_CH = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [N_CH-1:0] wr_bits,
   input  logic [N_CH-1:0] fail,
   output logic [N_CH-1:0] q
);
   for (genvar k = 0; k < N_CH; k++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        q[k] <= 1'b0;
         else if (fail[k])  q[k] <= 1'b0;
         else if (wr_en)    q[k] <= wr_bits[k];
      end
   end
endmodule

// File: rtl/wp_regbank.sv
module wp_regbank
   import wpr_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int N_CH   = 4,
   parameter logic [ADDR_W-1:0] FAULT_ADDR = '1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_req,
   input  logic                wr_is_mem,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [7:0]          wr_data,
   input  logic                wp_pin,
   input  logic                vpp_ok,
   input  logic [N_CH-1:0]     fail_pulse,
   input  logic [ADDR_W-1:0]   rd_addr,
   output logic                wr_permit,
   output logic [7:0]          rd_data,
   output logic [1:0]          rst_dly_code,
   output logic [2*N_CH-1:0]   ch_dly_code
);
   localparam int CD_W = 2 * N_CH;

   if (N_CH < 1 || N_CH > 4) begin : g_bad_nch
      $error("wp_regbank: N_CH must lie in 1..4");
   end
   if (ADDR_W < 4) begin : g_bad_aw
      $error("wp_regbank: ADDR_W must be at least 4");
   end

   logic            wel_q;
   logic            wpen_q;
   logic [1:0]      bp_q;
   logic [1:0]      rdly_q;
   logic [CD_W-1:0] cdly_q;
   logic [N_CH-1:0] fault_q;
   tgt_e            tgt;

   wpr_permit #(.ADDR_W(ADDR_W), .FAULT_ADDR(FAULT_ADDR)) u_permit (
      .wr_req    (wr_req),
      .wr_is_mem (wr_is_mem),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .wel       (wel_q),
      .wpen      (wpen_q),
      .bp        (bp_q),
      .wp_pin    (wp_pin),
      .vpp_ok    (vpp_ok),
      .permit    (wr_permit),
      .tgt       (tgt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel_q  <= 1'b0;
         wpen_q <= 1'b0;
         bp_q   <= 2'b00;
         rdly_q <= 2'b00;
         cdly_q <= '0;
      end else if (wr_permit) begin
         unique case (tgt)
            TGT_LATCH: wel_q <= wr_data[7];
            TGT_PROT: begin
               wpen_q <= wr_data[7];
               bp_q   <= wr_data[4:3];
            end
            TGT_RDLY:  rdly_q <= wr_data[3:2];
            TGT_CDLY:  cdly_q <= wr_data[CD_W-1:0];
            default: ;
         endcase
      end
   end

   wpr_fault #(.N_CH(N_CH)) u_fault (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_permit && (tgt == TGT_FAULT)),
      .wr_bits (wr_data[N_CH-1:0]),
      .fail    (fail_pulse),
      .q       (fault_q)
   );

   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_W'(REG_LATCH))     rd_data[7] = wel_q;
      else if (rd_addr == ADDR_W'(REG_PROT)) begin
         rd_data[7]   = wpen_q;
         rd_data[4:3] = bp_q;
      end
      else if (rd_addr == ADDR_W'(REG_RDLY)) rd_data[3:2] = rdly_q;
      else if (rd_addr == ADDR_W'(REG_CDLY)) rd_data[CD_W-1:0] = cdly_q;
      else if (rd_addr == FAULT_ADDR)        rd_data[N_CH-1:0] = fault_q;
   end

   assign rst_dly_code = rdly_q;
   assign ch_dly_code  = cdly_q;
endmodule

// File: rtl/wpr_checker.sv
module wpr_checker #(
   parameter int ADDR_W = 8,
   parameter int N_CH   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_req,
   input logic              wr_is_mem,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [7:0]        wr_data,
   input logic              wp_pin,
   input logic              vpp_ok,
   input logic [N_CH-1:0]   fail_pulse,
   input logic              wr_permit,
   input logic [1:0]        rst_dly_code,
   input logic              wel_q,
   input logic              wpen_q,
   input logic [N_CH-1:0]   fault_q
);
   logic nv_reg_tgt;
   assign nv_reg_tgt = !wr_is_mem && (wr_addr >= ADDR_W'(1)) && (wr_addr <= ADDR_W'(3));

   // R2
   bad_latch_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !wr_is_mem && wr_addr == '0 && wr_data != 8'h80 && wr_data != 8'h00)
      |-> !wr_permit);

   // R3
   latch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !wel_q && (wr_is_mem || nv_reg_tgt)) |-> !wr_permit);

   // R5
   hw_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && nv_reg_tgt && wp_pin && wpen_q) |-> !wr_permit);

   // R9
   vpp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !vpp_ok && (wr_is_mem || nv_reg_tgt)) |-> !wr_permit);

   // R6
   rdly_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_permit && !wr_is_mem && wr_addr == ADDR_W'(2)) |=> $stable(rst_dly_code));

   // R7
   fail_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fail_pulse != '0) |=> ((fault_q & $past(fail_pulse)) == '0));
endmodule

bind wp_regbank wpr_checker #(.ADDR_W(ADDR_W), .N_CH(N_CH)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_req       (wr_req),
   .wr_is_mem    (wr_is_mem),
   .wr_addr      (wr_addr),
   .wr_data      (wr_data),
   .wp_pin       (wp_pin),
   .vpp_ok       (vpp_ok),
   .fail_pulse   (fail_pulse),
   .wr_permit    (wr_permit),
   .rst_dly_code (rst_dly_code),
   .wel_q        (wel_q),
   .wpen_q       (wpen_q),
   .fault_q      (fault_q)
);

// File: tb/tb_wp_regbank.sv
module tb_wp_regbank;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_req = 1'b0;
   logic       wr_is_mem = 1'b0;
   logic [7:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       wp_pin = 1'b0;
   logic       vpp_ok = 1'b0;
   logic [3:0] fail_pulse = '0;
   logic [7:0] rd_addr = '0;
   logic       wr_permit;
   logic [7:0] rd_data;
   logic [1:0] rst_dly_code;
   logic [7:0] ch_dly_code;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   wp_regbank dut (
      .clk (clk), .rst_n (rst_n), .wr_req (wr_req), .wr_is_mem (wr_is_mem),
      .wr_addr (wr_addr), .wr_data (wr_data), .wp_pin (wp_pin), .vpp_ok (vpp_ok),
      .fail_pulse (fail_pulse), .rd_addr (rd_addr), .wr_permit (wr_permit),
      .rd_data (rd_data), .rst_dly_code (rst_dly_code), .ch_dly_code (ch_dly_code)
   );

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   // drive a one-cycle write, check permit before the edge
   task automatic wr(input bit mem, input logic [7:0] a, input logic [7:0] d,
                     input bit exp_ok, input string tag);
      @(negedge clk);
      wr_req = 1'b1; wr_is_mem = mem; wr_addr = a; wr_data = d;
      #1 chk({7'b0, wr_permit}, {7'b0, exp_ok}, tag);
      @(negedge clk);
      wr_req = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
      rd_addr = a;
      #1 chk(rd_data, exp, tag);
   endtask

   task automatic t_reset;
      rd(8'h00, 8'h00, "R1 latch");
      rd(8'h01, 8'h00, "R1 prot");
      rd(8'h02, 8'h00, "R1 rdly");
      rd(8'h03, 8'h00, "R1 cdly");
      rd(8'hFF, 8'h00, "R1 fault");
      chk({6'b0, rst_dly_code}, 8'h00, "R1 rst code");
      chk(ch_dly_code, 8'h00, "R1 ch codes");
   endtask

   task automatic t_latch;
      vpp_ok = 1'b1;
      wr(0, 8'h02, 8'h0C, 0, "R3 reg refused latch closed");
      rd(8'h02, 8'h00, "R3 reg unchanged");
      wr(1, 8'h10, 8'h55, 0, "R3 mem refused latch closed");
      wr(0, 8'h00, 8'h81, 0, "R2 odd value refused");
      rd(8'h00, 8'h00, "R2 latch still closed");
      vpp_ok = 1'b0;
      wr(0, 8'h00, 8'h80, 1, "R2 open without vpp");
      rd(8'h00, 8'h80, "R2 latch open");
      vpp_ok = 1'b1;
   endtask

   task automatic t_fields;
      wr(0, 8'h02, 8'hFF, 1, "R6 rdly write");
      rd(8'h02, 8'h0C, "R10 rdly unused bits");
      chk({6'b0, rst_dly_code}, 8'h03, "R6 rst code");
      wr(0, 8'h03, 8'hE4, 1, "R6 cdly write");
      chk(ch_dly_code, 8'hE4, "R6 ch codes");
      chk({6'b0, ch_dly_code[1:0]}, 8'h00, "R6 ch0 field");
      chk({6'b0, ch_dly_code[7:6]}, 8'h03, "R6 ch3 field");
      wr(0, 8'h01, 8'h67, 1, "R10 prot write");
      rd(8'h01, 8'h00, "R10 prot unused bits");
   endtask

   task automatic t_blocks;
      wr(0, 8'h01, 8'h08, 1, "R4 bp=01");
      wr(1, 8'hC0, 8'h11, 0, "R4 bp=01 C0 refused");
      wr(1, 8'hBF, 8'h11, 1, "R4 bp=01 BF allowed");
      wr(0, 8'h01, 8'h10, 1, "R4 bp=10");
      wr(1, 8'h80, 8'h11, 0, "R4 bp=10 80 refused");
      wr(1, 8'h7F, 8'h11, 1, "R4 bp=10 7F allowed");
      wr(0, 8'h01, 8'h18, 1, "R4 bp=11");
      wr(1, 8'h00, 8'h11, 0, "R4 bp=11 00 refused");
      wr(0, 8'h01, 8'h00, 1, "R4 bp=00");
      wr(1, 8'hFF, 8'h11, 1, "R4 bp=00 FF allowed");
   endtask

   task automatic t_hwlock;
      wr(0, 8'h01, 8'h88, 1, "R5 set lock bit");
      rd(8'h01, 8'h88, "R5 prot readback");
      wp_pin = 1'b1;
      wr(0, 8'h02, 8'h04, 0, "R5 reg refused under lock");
      rd(8'h02, 8'h0C, "R5 reg unchanged");
      wr(1, 8'h10, 8'h22, 1, "R5 unfenced mem allowed");
      wr(1, 8'hC4, 8'h22, 0, "R5 fenced mem refused");
      wr(0, 8'h00, 8'h80, 1, "R2 latch write under lock");
      wp_pin = 1'b0;
      wr(0, 8'h01, 8'h00, 1, "R5 pin low releases");
      rd(8'h01, 8'h00, "R5 prot cleared");
   endtask

   task automatic t_vpp;
      vpp_ok = 1'b0;
      wr(0, 8'h03, 8'h00, 0, "R9 reg refused no vpp");
      chk(ch_dly_code, 8'hE4, "R9 codes unchanged");
      wr(1, 8'h20, 8'h00, 0, "R9 mem refused no vpp");
      vpp_ok = 1'b1;
   endtask

   task automatic t_fault;
      wr(0, 8'h00, 8'h00, 1, "R2 close latch");
      rd(8'h00, 8'h00, "R2 latch closed");
      vpp_ok = 1'b0;
      wr(0, 8'hFF, 8'hFF, 1, "R8 fault write no latch no vpp");
      rd(8'hFF, 8'h0F, "R10 fault upper bits");
      @(negedge clk); fail_pulse = 4'b0100;
      @(negedge clk); fail_pulse = 4'b0000;
      rd(8'hFF, 8'h0B, "R7 ch2 cleared");
      @(negedge clk);
      wr_req = 1'b1; wr_is_mem = 1'b0; wr_addr = 8'hFF; wr_data = 8'h0F;
      fail_pulse = 4'b0001;
      @(negedge clk);
      wr_req = 1'b0; fail_pulse = 4'b0000;
      rd(8'hFF, 8'h0E, "R7 fail wins over write");
      vpp_ok = 1'b1;
   endtask

   task automatic t_badaddr;
      wr(0, 8'h00, 8'h80, 1, "R2 reopen");
      wr(0, 8'h05, 8'hAA, 0, "R11 unknown reg refused");
      rd(8'h05, 8'h00, "R11 unknown reads zero");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_latch();
      t_fields();
      t_blocks();
      t_hwlock();
      t_vpp();
      t_fault();
      t_badaddr();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule